// File: doc/BRIEF.md
# Tuner Reference Divider and Phase-Frequency Detector

This block sits in the frequency-synthesis loop of a broadcast tuner. It divides a crystal reference clock by 512, 640 or 1024 to set the comparison rate, then compares each divided reference edge with a feedback pulse from the main divider. The comparison uses a two-flop phase-frequency detector that drives digital pump-up and pump-down enables for an external charge pump. With a 4 MHz crystal the three ratios give comparison rates of 7.8125 kHz, 6.25 kHz and 3.90625 kHz.

A 3-bit mode code selects the ratio. Four codes map to fixed ratios. The extended code takes the ratio from two register bits. Two more register bits control the pump: one blanks both enables, and the other asks for the high or the low pump current.

A lock detector watches how long one enable stays active on its own in each comparison. A run of tight comparisons raises the lock flag, and a single wide one drops it at once.

Top module: `tunref_pfd`

## Requirements
- R1: While `rstN` is low and in the cycle after its release, `pumpUp`, `pumpDn` and `locked` are 0.
- R2: Fixed mode codes select the reference ratio: code 0 gives 1024 clocks, code 1 gives 512, code 2 gives 640 and code 3 gives 512. With pump blanking off, `pumpUp` rises exactly once per ratio clocks.
- R3: Codes 4 to 7 are extended. If `extR0` is 0 the ratio is 640, whatever `extR1` is. If `extR0` is 1, `extR1`=0 gives 1024 and `extR1`=1 gives 512.
- R4: A reference edge sets the up flop and a `fbPulse` sampled high sets the down flop, each visible one cycle later. When both flops are high for a cycle, both clear at the next edge. Edges that arrive in that clearing cycle are dropped.
- R5: While `pumpOff` is 1, `pumpUp` and `pumpDn` are 0 in the same cycle. Detection and lock tracking go on unchanged.
- R6: `pumpHigh` follows `pumpHiSel`: 1 requests the high current (200 µA) and 0 requests the low current (50 µA).
- R7: The width of a comparison is the number of cycles in which exactly one flop is set. `locked` rises at the edge that completes the 4th consecutive comparison of width below 2.
- R8: At the edge that ends the 2nd single-active cycle of a comparison, `locked` falls and the run count restarts. This also happens when the feedback never arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 3 | Step mode code |
| extR1 | input | 1 | Extended-mode ratio bit, high |
| extR0 | input | 1 | Extended-mode ratio bit, low |
| pumpOff | input | 1 | Blank both pump enables |
| pumpHiSel | input | 1 | Pump current request |
| fbPulse | input | 1 | Feedback divider pulse, synchronous to clk |
| pumpUp | output | 1 | Charge-pump source enable |
| pumpDn | output | 1 | Charge-pump sink enable |
| pumpHigh | output | 1 | High-current request level |
| locked | output | 1 | Lock indication |

## Verification
The hardest case to reach from the ports is the exact edge of the lock window. A comparison of width 1 must keep the lock, and width 2 must drop it at the edge that ends the second single-active cycle rather than when the comparison completes. The stimulus places every feedback pulse at a programmed offset from the modelled reference edge. Offsets of 0, 1, 2 and 3 cycles, a feedback leading by one cycle, and a run with no feedback at all cover both sides of that boundary. Ratio switches in the middle of a period, including to a shorter ratio, test the divider wrap on every clock against the behavioural model.

// File: rtl/tunref_pkg.sv
package tunref_pkg;

  typedef enum logic [1:0] {
    RATIO_LO  = 2'd0,
    RATIO_MID = 2'd1,
    RATIO_HI  = 2'd2
  } ratio_e;

  // Strobes handed from the divider control to the detector datapath
  typedef struct packed {
    logic refEdge;
    logic pumpBlank;
  } pfd_ctrl_t;

  localparam int MODE_W = 3;

endpackage

// File: rtl/tunref_ctrl.sv
module tunref_ctrl
  import tunref_pkg::*;
#(
  parameter int DIV_HI  = 1024,
  parameter int DIV_MID = 640,
  parameter int DIV_LO  = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              extR1,
  input  logic              extR0,
  input  logic              pumpOff,
  output pfd_ctrl_t         strobe
);

  localparam int CNT_W = $clog2(DIV_HI);
  localparam logic [CNT_W-1:0] LAST_HI  = CNT_W'(DIV_HI - 1);
  localparam logic [CNT_W-1:0] LAST_MID = CNT_W'(DIV_MID - 1);
  localparam logic [CNT_W-1:0] LAST_LO  = CNT_W'(DIV_LO - 1);

  ratio_e           ratioSel;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] refCnt;
  logic             refEdge;

  // Mode decode: fixed codes first, everything above them is extended
  always_comb begin
    case (modeSel)
      3'd0:    ratioSel = RATIO_HI;
      3'd1:    ratioSel = RATIO_LO;
      3'd2:    ratioSel = RATIO_MID;
      3'd3:    ratioSel = RATIO_LO;
      default: ratioSel = !extR0 ? RATIO_MID : (extR1 ? RATIO_LO : RATIO_HI);
    endcase
  end

  always_comb begin
    case (ratioSel)
      RATIO_HI:  lastIdx = LAST_HI;
      RATIO_MID: lastIdx = LAST_MID;
      default:   lastIdx = LAST_LO;
    endcase
  end

  // Magnitude compare so a shrink of the ratio mid-period wraps at once
  assign refEdge = (refCnt >= lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
    end else if (refEdge) begin
      refCnt <= '0;
    end else begin
      refCnt <= refCnt + 1'b1;
    end
  end

  assign strobe.refEdge   = refEdge;
  assign strobe.pumpBlank = pumpOff;

  // R2: every edge restarts the count
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.refEdge |=> (refCnt == '0));

  // R2: ratios are far above one, so edges never come back to back
  a_r2_no_double_edge: assert property (@(posedge clk) disable iff (!rstN)
    strobe.refEdge |=> !strobe.refEdge);

endmodule

// File: rtl/tunref_dp.sv
module tunref_dp
  import tunref_pkg::*;
#(
  parameter int LOCK_RUNS   = 4,
  parameter int WIDTH_LIMIT = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  pfd_ctrl_t strobe,
  input  logic      fbPulse,
  output logic      pumpUp,
  output logic      pumpDn,
  output logic      locked
);

  localparam int WID_W  = $clog2(WIDTH_LIMIT + 1);
  localparam int GOOD_W = $clog2(LOCK_RUNS + 1);
  localparam logic [WID_W-1:0]  WID_MAX   = WID_W'(WIDTH_LIMIT);
  localparam logic [WID_W-1:0]  WID_EDGE  = WID_W'(WIDTH_LIMIT - 1);
  localparam logic [GOOD_W-1:0] GOOD_FULL = GOOD_W'(LOCK_RUNS);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_RUNS - 1);

  logic              upQ;
  logic              dnQ;
  logic              pairDone;
  logic              singleOn;
  logic [WID_W-1:0]  widthCnt;
  logic [GOOD_W-1:0] goodCnt;
  logic              lockQ;

  assign pairDone = upQ & dnQ;
  assign singleOn = upQ ^ dnQ;

  // Two-flop detector with reset on coincidence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else if (pairDone) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= upQ | strobe.refEdge;
      dnQ <= dnQ | fbPulse;
    end
  end

  // Comparison width and lock qualification
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
      goodCnt  <= '0;
      lockQ    <= 1'b0;
    end else if (pairDone) begin
      widthCnt <= '0;
      if (widthCnt < WID_MAX) begin
        if (goodCnt >= GOOD_LAST) begin
          goodCnt <= GOOD_FULL;
          lockQ   <= 1'b1;
        end else begin
          goodCnt <= goodCnt + 1'b1;
        end
      end
    end else if (singleOn) begin
      if (widthCnt < WID_MAX) begin
        widthCnt <= widthCnt + 1'b1;
      end
      if (widthCnt >= WID_EDGE) begin
        goodCnt <= '0;
        lockQ   <= 1'b0;
      end
    end
  end

  assign pumpUp = upQ & ~strobe.pumpBlank;
  assign pumpDn = dnQ & ~strobe.pumpBlank;
  assign locked = lockQ;

  // R4: a full pair never survives a second cycle
  a_r4_pair_clears: assert property (@(posedge clk) disable iff (!rstN)
    pairDone |=> (!upQ && !dnQ));

  // R4: the up flop is only ever set by a reference edge
  a_r4_up_from_ref: assert property (@(posedge clk) disable iff (!rstN)
    $rose(upQ) |-> $past(strobe.refEdge));

  // R7: lock only rises at the end of a comparison
  a_r7_lock_on_pair: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> $past(pairDone));

  // R8: lock only falls while one side is active alone
  a_r8_drop_on_single: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockQ) |-> $past(singleOn));

endmodule

// File: rtl/tunref_pfd.sv
module tunref_pfd
  import tunref_pkg::*;
#(
  parameter int DIV_HI      = 1024,
  parameter int DIV_MID     = 640,
  parameter int DIV_LO      = 512,
  parameter int LOCK_RUNS   = 4,
  parameter int WIDTH_LIMIT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic       extR1,
  input  logic       extR0,
  input  logic       pumpOff,
  input  logic       pumpHiSel,
  input  logic       fbPulse,
  output logic       pumpUp,
  output logic       pumpDn,
  output logic       pumpHigh,
  output logic       locked
);

  pfd_ctrl_t ctrlStrobe;

  tunref_ctrl #(
    .DIV_HI (DIV_HI),
    .DIV_MID(DIV_MID),
    .DIV_LO (DIV_LO)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .modeSel(modeSel),
    .extR1  (extR1),
    .extR0  (extR0),
    .pumpOff(pumpOff),
    .strobe (ctrlStrobe)
  );

  tunref_dp #(
    .LOCK_RUNS  (LOCK_RUNS),
    .WIDTH_LIMIT(WIDTH_LIMIT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (ctrlStrobe),
    .fbPulse(fbPulse),
    .pumpUp (pumpUp),
    .pumpDn (pumpDn),
    .locked (locked)
  );

  // Current request is a static level toward the analog pump
  assign pumpHigh = pumpHiSel;

endmodule

// File: tb/tunref_pfd_tb.sv
module tunref_pfd_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic       extR1 = 1'b0;
  logic       extR0 = 1'b1;
  logic       pumpOff = 1'b0;
  logic       pumpHiSel = 1'b0;
  logic       fbPulse = 1'b0;
  logic       pumpUp, pumpDn, pumpHigh, locked;

  int checks = 0;
  int errors = 0;
  int cycNo = 0;
  bit done = 0;

  // stimulus knobs
  bit fbOn = 0;
  int fbDelay = 0;

  // reference model state
  int mCnt = 0, mW = 0, mGood = 0, sinceRef = 0;
  bit mUp = 0, mDn = 0, mLock = 0, mRef = 0;

  // rise tracking of pumpUp
  int lastRise = -1, lastInterval = 0, upRises = 0, negCyc = 0;
  bit upPrev = 0;

  tunref_pfd u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .extR1(extR1), .extR0(extR0),
    .pumpOff(pumpOff), .pumpHiSel(pumpHiSel), .fbPulse(fbPulse),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .pumpHigh(pumpHigh), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ratioOf(logic [2:0] m, logic r1, logic r0);
    case (m)
      3'd0: return 1024;
      3'd1: return 512;
      3'd2: return 640;
      3'd3: return 512;
      default: return r0 ? (r1 ? 512 : 1024) : 640;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural model, stepped at each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mUp = 0; mDn = 0; mW = 0; mGood = 0; mLock = 0; sinceRef = 0;
    end else begin
      mRef = (mCnt >= ratioOf(modeSel, extR1, extR0) - 1);
      mCnt = mRef ? 0 : mCnt + 1;
      sinceRef = mRef ? 0 : sinceRef + 1;
      if (mUp && mDn) begin
        if (mW < 2) begin
          mGood++;
          if (mGood >= 4) begin mGood = 4; mLock = 1; end
        end
        mW = 0; mUp = 0; mDn = 0;
      end else begin
        if (mUp != mDn) begin
          mW++;
          if (mW >= 2) begin mLock = 0; mGood = 0; end
        end
        if (mRef) mUp = 1;
        if (fbPulse) mDn = 1;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycNo++;
    if (cycNo > WATCHDOG && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycNo, WATCHDOG);
      finishRun();
    end
  end

  // one cycle: compare at the falling edge, then drive feedback
  task automatic runCycles(int n);
    repeat (n) begin
      @(negedge clk);
      chk(pumpUp == (mUp && !pumpOff), "R4/R5", "pumpUp", pumpUp, mUp && !pumpOff);
      chk(pumpDn == (mDn && !pumpOff), "R4/R5", "pumpDn", pumpDn, mDn && !pumpOff);
      chk(pumpHigh == pumpHiSel, "R6", "pumpHigh", pumpHigh, pumpHiSel);
      chk(locked == mLock, "R7/R8", "locked", locked, mLock);
      if (pumpUp && !upPrev) begin
        if (lastRise >= 0) lastInterval = negCyc - lastRise;
        lastRise = negCyc;
        upRises++;
      end
      upPrev = pumpUp;
      negCyc++;
      if (!fbOn) fbPulse = 1'b0;
      else if (fbDelay == 0) fbPulse = (mCnt >= ratioOf(modeSel, extR1, extR0) - 1);
      else fbPulse = (sinceRef == fbDelay - 1);
    end
  endtask

  task automatic setMode(logic [2:0] m, logic r1, logic r0);
    modeSel = m; extR1 = r1; extR0 = r0;
  endtask

  task automatic checkPeriod(int exp, string req);
    runCycles(4 * exp + 8);
    chk(lastInterval == exp, req, "up period", lastInterval, exp);
  endtask

  initial begin
    int risesBefore;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!pumpUp && !pumpDn && !locked, "R1", "outputs in reset", {pumpUp, pumpDn, locked}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!pumpUp && !pumpDn && !locked, "R1", "outputs after release", {pumpUp, pumpDn, locked}, 0);

    // R2/R7: code 0, in-phase feedback, lock acquired
    fbOn = 1; fbDelay = 0;
    checkPeriod(1024, "R2");
    chk(locked == 1'b1, "R7", "lock with zero width", locked, 1);

    // R7: width 1 keeps lock
    fbDelay = 1;
    runCycles(3 * 1024);
    chk(locked == 1'b1, "R7", "lock with width 1", locked, 1);

    // R8: width 2 drops lock
    fbDelay = 2;
    runCycles(2 * 1024);
    chk(locked == 1'b0, "R8", "unlock with width 2", locked, 0);

    // R7: reacquire, then width 3
    fbDelay = 1;
    runCycles(6 * 1024);
    chk(locked == 1'b1, "R7", "relock", locked, 1);
    fbDelay = 3;
    runCycles(1024 + 8);
    chk(locked == 1'b0, "R8", "unlock with width 3", locked, 0);

    // R2: remaining fixed codes
    fbDelay = 0;
    setMode(3'd1, 1'b0, 1'b1); checkPeriod(512, "R2");
    setMode(3'd2, 1'b0, 1'b1); checkPeriod(640, "R2");
    setMode(3'd3, 1'b0, 1'b1); checkPeriod(512, "R2");

    // R3: extended codes
    setMode(3'd4, 1'b0, 1'b1); checkPeriod(1024, "R3");
    setMode(3'd4, 1'b1, 1'b1); checkPeriod(512, "R3");
    setMode(3'd4, 1'b0, 1'b0); checkPeriod(640, "R3");
    setMode(3'd4, 1'b1, 1'b0); checkPeriod(640, "R3");
    setMode(3'd6, 1'b1, 1'b1); checkPeriod(512, "R3");
    chk(locked == 1'b1, "R7", "lock across ratio switches", locked, 1);

    // R4: feedback leading by one cycle keeps lock
    fbDelay = 511;
    runCycles(5 * 512);
    chk(locked == 1'b1, "R4", "lock with feedback leading", locked, 1);

    // R5/R6: blanking and current request
    fbDelay = 0;
    pumpOff = 1'b1; pumpHiSel = 1'b1;
    risesBefore = upRises;
    runCycles(3 * 512);
    chk(upRises == risesBefore, "R5", "up pulses while blanked", upRises - risesBefore, 0);
    chk(locked == 1'b1, "R5", "lock kept while blanked", locked, 1);
    chk(pumpHigh == 1'b1, "R6", "high current request", pumpHigh, 1);
    pumpOff = 1'b0; pumpHiSel = 1'b0;
    runCycles(2 * 512);
    chk(pumpHigh == 1'b0, "R6", "low current request", pumpHigh, 0);
    chk(upRises > risesBefore, "R5", "up pulses after unblank", upRises - risesBefore, 2);

    // R8: feedback stops entirely
    fbOn = 0;
    runCycles(2 * 512);
    chk(locked == 1'b0, "R8", "unlock without feedback", locked, 0);

    done = 1;
    finishRun();
  end

endmodule